// File: doc/BRIEF.md
# Banked Pad Multiplexer with Direction Control

This block connects peripheral signals to bidirectional I/O pad cells. Each pad is treated as a triplet: a value driven towards the pad, an output enable that sets its direction, and the value read back from the pad. Pads are organised in two kinds of bank. In the muxed bank each pad has a small select register that picks one of up to four function columns. The chosen column supplies the pad's output and output enable through a straight selector. In the dedicated bank every pad is wired one-to-one to a single function, with no select logic on the path, so fast interfaces see only wires.

Function inputs coming back from the muxed bank are resolved with priority logic. Pad `p` in column `c` serves function slot `p mod FUNCS` of that column, so several pads can reach the same function input. The lowest-numbered pad that selects the column wins, and a function input that no pad selects reads 0. Each column is either bidirectional, in which case the function provides its own per-pin enable, or output-only, in which case the pad enable is held high. Select values that point past the bank's number of columns leave the pad tri-stated.

Top module: `pad_mux_banked`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears every pad's select register to 0, so column 0 drives every muxed pad until a new select is written.
- R2: On a rising clock edge with `sel_wr_en[p]` high, pad p's select register loads `sel_wr_data[2p+1:2p]`, and the new column takes effect from the following cycle. With `sel_wr_en[p]` low, the register holds its value whatever `sel_wr_data` carries.
- R3: For a muxed pad p whose select value s is below MUX_WAYS, `mpad_out[p]` equals `mfn_out[s*FUNCS + (p mod FUNCS)]`, combinationally.
- R4: When column s is bidirectional (bit s of COL_BIDIR is 1, default 4'b0101), `mpad_oe[p]` equals `mfn_oe[s*FUNCS + (p mod FUNCS)]`. When column s is output-only, `mpad_oe[p]` is 1.
- R5: A muxed pad whose select value is MUX_WAYS or more (value 3 with the default of three columns) drives `mpad_out` 0 and `mpad_oe` 0.
- R6: Function input `mfn_in[c*FUNCS + f]` carries `mpad_in[p]` for the lowest-numbered pad p with select value c and p mod FUNCS equal to f.
- R7: A function input that no pad currently selects reads 0.
- R8: In the dedicated bank, `dpad_out` equals `dfn_out`, `dpad_oe` equals `dfn_oe` and `dfn_in` equals `dpad_in`, bit for bit, regardless of any muxed-bank select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the select registers |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised |
| sel_wr_en | input | MUX_PADS (8) | Per-pad select write enable |
| sel_wr_data | input | 2*MUX_PADS (16) | Per-pad 2-bit column select values |
| mfn_out | input | MUX_WAYS*FUNCS (12) | Function outputs, index column*FUNCS+slot |
| mfn_oe | input | MUX_WAYS*FUNCS (12) | Function output enables, same indexing |
| mfn_in | output | MUX_WAYS*FUNCS (12) | Function inputs after priority routing |
| mpad_out | output | MUX_PADS (8) | Muxed pad output values |
| mpad_oe | output | MUX_PADS (8) | Muxed pad output enables |
| mpad_in | input | MUX_PADS (8) | Muxed pad input values |
| dfn_out | input | DED_PADS (4) | Dedicated function outputs |
| dfn_oe | input | DED_PADS (4) | Dedicated function output enables |
| dfn_in | output | DED_PADS (4) | Dedicated function inputs |
| dpad_out | output | DED_PADS (4) | Dedicated pad output values |
| dpad_oe | output | DED_PADS (4) | Dedicated pad output enables |
| dpad_in | input | DED_PADS (4) | Dedicated pad input values |

## Verification
The assertions assume that `rst_n` has already been synchronised to `clk`, and that select writes and all function and pad values change only between clock edges. They do not assume that select values are legal: values past the last column are expected, and the tri-state check covers them. The stimulus drives every input on the falling edge and releases reset away from the rising edge. It writes random 2-bit selects that include the unassigned code, and it writes to several pads at once, so that two pads often reach the same function input and exercise the precedence rule.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
  localparam int MAX_COLS = 4;
  localparam int SEL_W    = $clog2(MAX_COLS);

  typedef logic [SEL_W-1:0] col_sel_t;
endpackage

// File: rtl/padmux_selreg.sv
module padmux_selreg
  import padmux_pkg::*;
#(
  parameter int NPADS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPADS-1:0]       wr_en,
  input  logic [NPADS*SEL_W-1:0] wr_data,
  output logic [NPADS*SEL_W-1:0] sel_q
);

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    col_sel_t sel_r;
    col_sel_t sel_nxt;

    always_comb begin
      sel_nxt = wr_data[p*SEL_W +: SEL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_r <= '0;
      end else if (wr_en[p]) begin
        sel_r <= sel_nxt;
      end
    end

    assign sel_q[p*SEL_W +: SEL_W] = sel_r;

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[p] |=> sel_q[p*SEL_W +: SEL_W] == $past(wr_data[p*SEL_W +: SEL_W]));

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[p] |=> $stable(sel_q[p*SEL_W +: SEL_W]));
  end

endmodule

// File: rtl/padmux_outsel.sv
module padmux_outsel
  import padmux_pkg::*;
#(
  parameter int                  NPADS = 8,
  parameter int                  WAYS  = 3,
  parameter int                  FUNCS = 4,
  parameter logic [MAX_COLS-1:0] BIDIR = 4'b0101
) (
  input  logic [NPADS*SEL_W-1:0] sel,
  input  logic [WAYS*FUNCS-1:0]  fn_out,
  input  logic [WAYS*FUNCS-1:0]  fn_oe,
  output logic [NPADS-1:0]       pad_out,
  output logic [NPADS-1:0]       pad_oe
);

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    localparam int SLOT = p % FUNCS;
    col_sel_t s;
    logic     o_v;
    logic     e_v;

    assign s = sel[p*SEL_W +: SEL_W];

    always_comb begin
      o_v = 1'b0;
      e_v = 1'b0;
      for (int c = 0; c < WAYS; c++) begin
        if (s == SEL_W'(c)) begin
          o_v = fn_out[c*FUNCS + SLOT];
          e_v = BIDIR[c] ? fn_oe[c*FUNCS + SLOT] : 1'b1;
        end
      end
    end

    assign pad_out[p] = o_v;
    assign pad_oe[p]  = e_v;
  end

endmodule

// File: rtl/padmux_inprio.sv
module padmux_inprio
  import padmux_pkg::*;
#(
  parameter int NPADS = 8,
  parameter int WAYS  = 3,
  parameter int FUNCS = 4
) (
  input  logic [NPADS*SEL_W-1:0] sel,
  input  logic [NPADS-1:0]       pad_in,
  output logic [WAYS*FUNCS-1:0]  fn_in
);

  for (genvar c = 0; c < WAYS; c++) begin : g_col
    for (genvar f = 0; f < FUNCS; f++) begin : g_fn
      logic in_v;

      // Walk from the highest pad down so the lowest matching pad is last to write.
      always_comb begin
        in_v = 1'b0;
        for (int p = NPADS - 1; p >= 0; p--) begin
          if ((p % FUNCS) == f && sel[p*SEL_W +: SEL_W] == SEL_W'(c)) begin
            in_v = pad_in[p];
          end
        end
      end

      assign fn_in[c*FUNCS + f] = in_v;
    end
  end

endmodule

// File: rtl/padmux_dedicated.sv
module padmux_dedicated #(
  parameter int NPADS = 4
) (
  input  logic [NPADS-1:0] fn_out,
  input  logic [NPADS-1:0] fn_oe,
  output logic [NPADS-1:0] fn_in,
  output logic [NPADS-1:0] pad_out,
  output logic [NPADS-1:0] pad_oe,
  input  logic [NPADS-1:0] pad_in
);

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    assign pad_out[p] = fn_out[p];
    assign pad_oe[p]  = fn_oe[p];
    assign fn_in[p]   = pad_in[p];
  end

endmodule

// File: rtl/pad_mux_banked.sv
module pad_mux_banked
  import padmux_pkg::*;
#(
  parameter int                  MUX_PADS  = 8,
  parameter int                  MUX_WAYS  = 3,
  parameter int                  FUNCS     = 4,
  parameter int                  DED_PADS  = 4,
  parameter logic [MAX_COLS-1:0] COL_BIDIR = 4'b0101
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [MUX_PADS-1:0]         sel_wr_en,
  input  logic [MUX_PADS*SEL_W-1:0]   sel_wr_data,
  input  logic [MUX_WAYS*FUNCS-1:0]   mfn_out,
  input  logic [MUX_WAYS*FUNCS-1:0]   mfn_oe,
  output logic [MUX_WAYS*FUNCS-1:0]   mfn_in,
  output logic [MUX_PADS-1:0]         mpad_out,
  output logic [MUX_PADS-1:0]         mpad_oe,
  input  logic [MUX_PADS-1:0]         mpad_in,
  input  logic [DED_PADS-1:0]         dfn_out,
  input  logic [DED_PADS-1:0]         dfn_oe,
  output logic [DED_PADS-1:0]         dfn_in,
  output logic [DED_PADS-1:0]         dpad_out,
  output logic [DED_PADS-1:0]         dpad_oe,
  input  logic [DED_PADS-1:0]         dpad_in
);

  localparam int SEL_BITS = MUX_PADS * SEL_W;

  logic [SEL_BITS-1:0] sel_q;

  padmux_selreg #(.NPADS(MUX_PADS)) u_selreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sel_wr_en),
    .wr_data (sel_wr_data),
    .sel_q   (sel_q)
  );

  padmux_outsel #(
    .NPADS (MUX_PADS),
    .WAYS  (MUX_WAYS),
    .FUNCS (FUNCS),
    .BIDIR (COL_BIDIR)
  ) u_outsel (
    .sel     (sel_q),
    .fn_out  (mfn_out),
    .fn_oe   (mfn_oe),
    .pad_out (mpad_out),
    .pad_oe  (mpad_oe)
  );

  padmux_inprio #(
    .NPADS (MUX_PADS),
    .WAYS  (MUX_WAYS),
    .FUNCS (FUNCS)
  ) u_inprio (
    .sel    (sel_q),
    .pad_in (mpad_in),
    .fn_in  (mfn_in)
  );

  padmux_dedicated #(.NPADS(DED_PADS)) u_dedicated (
    .fn_out  (dfn_out),
    .fn_oe   (dfn_oe),
    .fn_in   (dfn_in),
    .pad_out (dpad_out),
    .pad_oe  (dpad_oe),
    .pad_in  (dpad_in)
  );

  for (genvar p = 0; p < MUX_PADS; p++) begin : g_chk
    if (MUX_WAYS < MAX_COLS) begin : g_unassigned
      // R5
      unassigned_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[p*SEL_W +: SEL_W] >= SEL_W'(MUX_WAYS)) |-> (!mpad_oe[p] && !mpad_out[p]));
    end
    for (genvar c = 0; c < MUX_WAYS; c++) begin : g_col
      if (!COL_BIDIR[c]) begin : g_outonly
        // R4
        outonly_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (sel_q[p*SEL_W +: SEL_W] == SEL_W'(c)) |-> mpad_oe[p]);
      end
    end
  end

endmodule

// File: tb/test_pad_mux_banked.sv
module test_pad_mux_banked;
  localparam int NP    = 8;
  localparam int WAYS  = 3;
  localparam int FUNCS = 4;
  localparam int ND    = 4;
  localparam int NF    = WAYS * FUNCS;
  localparam logic [3:0] BIDIR = 4'b0101;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   sel_wr_en = '0;
  logic [2*NP-1:0] sel_wr_data = '0;
  logic [NF-1:0]   mfn_out = '0, mfn_oe = '0;
  logic [NF-1:0]   mfn_in;
  logic [NP-1:0]   mpad_out, mpad_oe;
  logic [NP-1:0]   mpad_in = '0;
  logic [ND-1:0]   dfn_out = '0, dfn_oe = '0, dpad_in = '0;
  logic [ND-1:0]   dfn_in, dpad_out, dpad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int msel [NP];

  always #5 clk = ~clk;

  pad_mux_banked i_pad_mux_banked (
    .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
    .mfn_out(mfn_out), .mfn_oe(mfn_oe), .mfn_in(mfn_in),
    .mpad_out(mpad_out), .mpad_oe(mpad_oe), .mpad_in(mpad_in),
    .dfn_out(dfn_out), .dfn_oe(dfn_oe), .dfn_in(dfn_in),
    .dpad_out(dpad_out), .dpad_oe(dpad_oe), .dpad_in(dpad_in)
  );

  // Behavioural model of the select registers
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) msel[p] <= 0;
    end else begin
      for (int p = 0; p < NP; p++)
        if (sel_wr_en[p]) msel[p] <= int'(sel_wr_data[2*p +: 2]);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int p = 0; p < NP; p++) begin
      int s = msel[p];
      int eo = 0;
      int ee = 0;
      if (s < WAYS) begin
        eo = int'(mfn_out[s*FUNCS + p%FUNCS]);
        ee = BIDIR[s] ? int'(mfn_oe[s*FUNCS + p%FUNCS]) : 1;
        chk("R3", $sformatf("mpad_out[%0d]", p), int'(mpad_out[p]), eo);
        chk("R4", $sformatf("mpad_oe[%0d]", p), int'(mpad_oe[p]), ee);
      end else begin
        chk("R5", $sformatf("mpad_out[%0d]", p), int'(mpad_out[p]), 0);
        chk("R5", $sformatf("mpad_oe[%0d]", p), int'(mpad_oe[p]), 0);
      end
    end
    for (int c = 0; c < WAYS; c++) begin
      for (int f = 0; f < FUNCS; f++) begin
        int exp = 0;
        bit found = 1'b0;
        for (int p = 0; p < NP; p++) begin
          if (!found && msel[p] == c && p % FUNCS == f) begin
            exp = int'(mpad_in[p]);
            found = 1'b1;
          end
        end
        chk(found ? "R6" : "R7", $sformatf("mfn_in[%0d]", c*FUNCS+f),
            int'(mfn_in[c*FUNCS+f]), exp);
      end
    end
    chk("R8", "dpad_out", int'(dpad_out), int'(dfn_out));
    chk("R8", "dpad_oe", int'(dpad_oe), int'(dfn_oe));
    chk("R8", "dfn_in", int'(dfn_in), int'(dpad_in));
  endtask

  task automatic drive_random(bit allow_wr);
    mfn_out = NF'($urandom);
    mfn_oe  = NF'($urandom);
    mpad_in = NP'($urandom);
    dfn_out = ND'($urandom);
    dfn_oe  = ND'($urandom);
    dpad_in = ND'($urandom);
    sel_wr_data = (2*NP)'($urandom);
    sel_wr_en = (allow_wr && ($urandom % 3 == 0)) ? NP'($urandom) : '0;
  endtask

  initial begin
    // Reset state: every pad follows column 0 (R1)
    repeat (2) @(negedge clk);
    drive_random(1'b0);
    sel_wr_en = '1;
    #1;
    for (int p = 0; p < NP; p++) begin
      chk("R1", $sformatf("reset mpad_out[%0d]", p), int'(mpad_out[p]), int'(mfn_out[p%FUNCS]));
      chk("R1", $sformatf("reset mpad_oe[%0d]", p), int'(mpad_oe[p]), int'(mfn_oe[p%FUNCS]));
    end
    @(negedge clk);
    sel_wr_en = '0;
    #2 rst_n = 1'b1;

    // Directed: write pad 3 to column 2 (R2)
    @(negedge clk);
    sel_wr_en = '0; sel_wr_en[3] = 1'b1;
    sel_wr_data = '0; sel_wr_data[7:6] = 2'd2;
    @(negedge clk);
    sel_wr_en = '0;
    sel_wr_data = '1;
    mfn_out = '0; mfn_out[2*FUNCS+3] = 1'b1;
    #1 chk("R2", "pad3 after write", int'(mpad_out[3]), 1);
    @(negedge clk);
    #1 chk("R2", "pad3 hold without enable", int'(mpad_out[3]), 1);
    compare_all();

    // Directed: pads 0 and 4 both on column 1, lowest wins (R6)
    @(negedge clk);
    sel_wr_en = '0; sel_wr_en[0] = 1'b1; sel_wr_en[4] = 1'b1;
    sel_wr_data = '0; sel_wr_data[1:0] = 2'd1; sel_wr_data[9:8] = 2'd1;
    @(negedge clk);
    sel_wr_en = '0;
    mpad_in = '0; mpad_in[4] = 1'b1;
    #1 chk("R6", "pad0 beats pad4", int'(mfn_in[1*FUNCS+0]), 0);
    mpad_in[0] = 1'b1; mpad_in[4] = 1'b0;
    #1 chk("R6", "pad0 value seen", int'(mfn_in[1*FUNCS+0]), 1);
    compare_all();

    // Directed: pad 1 on unassigned column 3 (R5), column 1 slot 1 unused (R7)
    @(negedge clk);
    sel_wr_en = '0; sel_wr_en[1] = 1'b1; sel_wr_en[5] = 1'b1;
    sel_wr_data = '0; sel_wr_data[3:2] = 2'd3; sel_wr_data[11:10] = 2'd3;
    @(negedge clk);
    sel_wr_en = '0;
    mfn_out = '1; mfn_oe = '1; mpad_in = '1;
    #1;
    chk("R5", "pad1 oe on unassigned", int'(mpad_oe[1]), 0);
    chk("R5", "pad1 out on unassigned", int'(mpad_out[1]), 0);
    chk("R7", "col1 slot1 unselected", int'(mfn_in[1*FUNCS+1]), 0);
    compare_all();

    // Random traffic compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      drive_random(1'b1);
      #1 compare_all();
    end

    // Reset in mid-run returns to column 0 (R1)
    @(negedge clk);
    sel_wr_en = '0;
    rst_n = 1'b0;
    #1;
    for (int p = 0; p < NP; p++)
      chk("R1", $sformatf("re-reset mpad_out[%0d]", p), int'(mpad_out[p]), int'(mfn_out[p%FUNCS]));
    compare_all();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule